// File: doc/BRIEF.md
# Multi-Channel Trigger Conditioner

This block turns the raw hit lines of a row of detector channels, plus one summing channel, into clean, clocked trigger pulses. Each lane receives two asynchronous hit lines: a slower charge-comparator hit and a fast current-comparator hit that fires early to cut time walk. Both lines are synchronized. A rising edge on either one starts that lane's trigger. Each lane can be switched off on its own. Each lane also picks one of two output modes: a one-shot pulse of a programmed length, or a time-over-threshold pulse that tracks the synchronized charge-comparator level.

In time-over-threshold mode the lane also measures how long its pulse lasted, in clock cycles. It publishes that length with a one-cycle valid strobe. The pulses of the ordinary channels are ORed into one global trigger. A second readout-start output also includes the summing lane, so a summed signal alone can start a readout.

Top module: `trig_conditioner`

## Requirements
- R1: While reset is asserted, and right after it, every lane trigger, the global OR, the readout-start output, every duration-valid strobe and every duration value are 0.
- R2: In one-shot mode (tot_mode_i bit = 0), a rising edge of a lane's charge hit drives that lane's trigger high for exactly pulse_len_i clock cycles. The trigger rises on the third rising clock edge after the input changes. A hit level that stays high does not start another pulse.
- R3: In one-shot mode, a rising edge of the current hit alone starts the same pulse, including at the largest length of 63.
- R4: In one-shot mode, hit edges that arrive while a pulse is active are ignored. The pulse still ends after pulse_len_i cycles from its start. An edge that arrives after the pulse has ended starts a new pulse.
- R5: A pulse_len_i of 0 produces no pulse in one-shot mode.
- R6: In time-over-threshold mode (tot_mode_i bit = 1), the lane trigger equals the synchronized charge-hit level, with the same three-edge latency. Current-hit edges have no effect on it.
- R7: In time-over-threshold mode, the lane's duration strobe (tot_vld_o) pulses for one cycle on the clock edge where the trigger falls. The lane's field of tot_len_o, bits [lane*DUR_W +: DUR_W], then holds the number of cycles the trigger was high.
- R8: The reported duration saturates at 2^DUR_W-1.
- R9: When a lane's ch_en_i bit is 0, its trigger is 0 from the next clock on. The lane adds nothing to either OR output and emits no duration strobe.
- R10: trig_or_o is high exactly when one of the ordinary lanes 0..NUM_CH-1 is high. The summing lane (index NUM_CH) does not reach it. rd_trig_o is high when trig_or_o or the summing lane is high.
- R11: Each lane's mode setting applies to that lane alone. A hit shared by a one-shot lane and a time-over-threshold lane produces a pulse on each lane in its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_hit_i | input | NUM_CH+1 | Charge-comparator hit lines, asynchronous; top bit is the summing lane |
| c_hit_i | input | NUM_CH+1 | Current-comparator hit lines, asynchronous |
| ch_en_i | input | NUM_CH+1 | Per-lane trigger enable |
| tot_mode_i | input | NUM_CH+1 | Per-lane mode: 0 one-shot, 1 time-over-threshold |
| pulse_len_i | input | LEN_W | One-shot pulse length in clock cycles |
| trig_o | output | NUM_CH+1 | Conditioned per-lane triggers |
| trig_or_o | output | 1 | OR of the ordinary lanes' triggers |
| rd_trig_o | output | 1 | Readout start: trig_or_o or the summing lane |
| tot_len_o | output | (NUM_CH+1)*DUR_W | Last time-over-threshold duration per lane |
| tot_vld_o | output | NUM_CH+1 | One-cycle strobe when a lane's duration updates |

## Verification
The bench builds the block with NUM_CH = 4, so lane 4 is the summing lane, and with DUR_W = 5. The narrow duration counter lets a 40-cycle hit reach saturation at 31 within a short run. LEN_W keeps its default of 6, so the longest one-shot pulse of 63 cycles can be checked directly. The small lane count lets a single test drive ordinary lanes and the summing lane together. That makes the exclusion of the summing lane from the global OR visible at the ports.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;

    // Per-lane output mode; value matches the tot_mode_i bit encoding
    typedef enum logic {
        TRG_ONESHOT = 1'b0,
        TRG_OVERTHR = 1'b1
    } trg_mode_e;

endpackage

// File: rtl/trig_sync.sv
// Two-flop synchronizer with one extra stage for rising-edge detection.
module trig_sync #(
    parameter int W     = 2,
    parameter int LVL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     raw_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic [W-1:0]     rise_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.s3;
    assign lvl_o  = st_q.s2[LVL_W-1:0];

endmodule

// File: rtl/trig_lane.sv
// One trigger lane: one-shot or time-over-threshold conditioning.
module trig_lane
    import trig_cond_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  trg_mode_e        mode_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             q_lvl_i,
    input  logic             q_rise_i,
    input  logic             c_rise_i,
    output logic             trig_o,
    output logic [DUR_W-1:0] dur_o,
    output logic             dur_vld_o
);

    localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic             trig;
        logic [DUR_W-1:0] run;
        logic [DUR_W-1:0] dur;
        logic             vld;
    } lane_t;

    lane_t st_d, st_q;
    logic  hit;
    logic [DUR_W-1:0] run_inc;

    assign hit     = q_rise_i | c_rise_i;
    assign run_inc = (st_q.run == DUR_MAX) ? DUR_MAX : st_q.run + 1'b1;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!en_i) begin
            st_d.cnt  = '0;
            st_d.trig = 1'b0;
            st_d.run  = '0;
        end else if (mode_i == TRG_OVERTHR) begin
            st_d.cnt  = '0;
            st_d.trig = q_lvl_i;
            if (st_q.trig && q_lvl_i) begin
                st_d.run = run_inc;
            end else if (st_q.trig) begin
                st_d.dur = run_inc;
                st_d.vld = 1'b1;
                st_d.run = '0;
            end else begin
                st_d.run = '0;
            end
        end else begin
            st_d.run = '0;
            if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
            else if (hit)        st_d.cnt = len_i;
            st_d.trig = (st_d.cnt != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_o    = st_q.trig;
    assign dur_o     = st_q.dur;
    assign dur_vld_o = st_q.vld;

    // R9
    lane_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!trig_o && !dur_vld_o));

    // R2
    oneshot_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_o) && $past(en_i && mode_i == TRG_ONESHOT) |-> $past(hit));

    // R4
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && mode_i == TRG_ONESHOT && st_q.cnt != '0)
        |=> st_q.cnt == LEN_W'($past(st_q.cnt) - 1'b1));

    // R7
    dur_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dur_vld_o |-> (!trig_o && $past(trig_o)));

endmodule

// File: rtl/trig_conditioner.sv
module trig_conditioner
    import trig_cond_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int LEN_W  = 6,
    parameter int DUR_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH:0]               q_hit_i,
    input  logic [NUM_CH:0]               c_hit_i,
    input  logic [NUM_CH:0]               ch_en_i,
    input  logic [NUM_CH:0]               tot_mode_i,
    input  logic [LEN_W-1:0]              pulse_len_i,
    output logic [NUM_CH:0]               trig_o,
    output logic                          trig_or_o,
    output logic                          rd_trig_o,
    output logic [(NUM_CH+1)*DUR_W-1:0]   tot_len_o,
    output logic [NUM_CH:0]               tot_vld_o
);

    localparam int NLANE  = NUM_CH + 1;
    localparam int SUM_IX = NUM_CH;

    logic [NLANE-1:0]   q_lvl;
    logic [2*NLANE-1:0] rise;

    // Low half: charge hits (level exported), high half: current hits
    trig_sync #(.W(2*NLANE), .LVL_W(NLANE)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({c_hit_i, q_hit_i}),
        .lvl_o  (q_lvl),
        .rise_o (rise)
    );

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        trig_lane #(.LEN_W(LEN_W), .DUR_W(DUR_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (ch_en_i[i]),
            .mode_i    (trg_mode_e'(tot_mode_i[i])),
            .len_i     (pulse_len_i),
            .q_lvl_i   (q_lvl[i]),
            .q_rise_i  (rise[i]),
            .c_rise_i  (rise[NLANE+i]),
            .trig_o    (trig_o[i]),
            .dur_o     (tot_len_o[i*DUR_W +: DUR_W]),
            .dur_vld_o (tot_vld_o[i])
        );
    end

    assign trig_or_o = |trig_o[NUM_CH-1:0];
    assign rd_trig_o = trig_or_o | trig_o[SUM_IX];

    // R10
    sum_lane_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o[SUM_IX] && trig_o[NUM_CH-1:0] == '0) |-> (!trig_or_o && rd_trig_o));

endmodule

// File: tb/tb_trig_conditioner.sv
module tb_trig_conditioner;

    localparam int NCH = 4;
    localparam int NL  = NCH + 1;
    localparam int LW  = 6;
    localparam int DW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0] q_hit = '0, c_hit = '0, en = '1, mode = '0;
    logic [LW-1:0] plen = 6'd5;
    logic [NL-1:0] trig;
    logic trig_or, rd_trig;
    logic [NL*DW-1:0] tlen;
    logic [NL-1:0] tvld;

    int n_chk = 0, n_err = 0;
    int hi [NL];
    int vc [NL];
    int ln [NL];
    int orc, rdc;

    always #2 clk = ~clk;

    trig_conditioner #(.NUM_CH(NCH), .LEN_W(LW), .DUR_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .q_hit_i(q_hit), .c_hit_i(c_hit),
        .ch_en_i(en), .tot_mode_i(mode), .pulse_len_i(plen),
        .trig_o(trig), .trig_or_o(trig_or), .rd_trig_o(rd_trig),
        .tot_len_o(tlen), .tot_vld_o(tvld)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        for (int l = 0; l < NL; l++) begin hi[l] = 0; vc[l] = 0; ln[l] = -1; end
        orc = 0; rdc = 0;
    endtask

    task automatic watch(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int l = 0; l < NL; l++) begin
                hi[l] += int'(trig[l]);
                if (tvld[l]) begin vc[l]++; ln[l] = int'(tlen[l*DW +: DW]); end
            end
            orc += int'(trig_or);
            rdc += int'(rd_trig);
        end
    endtask

    task automatic t_reset();
        #1;
        chk(trig == '0 && !trig_or && !rd_trig, "R1 trig in reset", int'(trig), 0);
        chk(tvld == '0 && tlen == '0, "R1 duration in reset", int'(tlen), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(trig == '0 && tvld == '0, "R1 after reset", int'(trig), 0);
    endtask

    task automatic t_latency();
        plen = 6'd5;
        @(negedge clk); q_hit[0] = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk(trig[0] == 1'b0, "R2 not before third edge", int'(trig[0]), 0);
        @(posedge clk);
        #1 chk(trig[0] == 1'b1, "R2 high at third edge", int'(trig[0]), 1);
        clr(); watch(20);
        chk(hi[0] == 5, "R2 width with held level", hi[0], 5);
        chk(orc == 5 && rdc == 5, "R10 or follows lane 0", orc, 5);
        q_hit[0] = 1'b0; watch(5);
    endtask

    task automatic t_current();
        plen = 6'd63;
        @(negedge clk); c_hit[1] = 1'b1;
        @(negedge clk); c_hit[1] = 1'b0;
        clr(); watch(80);
        chk(hi[1] == 63, "R3 current hit width 63", hi[1], 63);
    endtask

    task automatic t_retrig();
        plen = 6'd10;
        clr();
        @(negedge clk); q_hit[2] = 1'b1;
        @(negedge clk); q_hit[2] = 1'b0;
        watch(3);
        c_hit[2] = 1'b1; watch(1); c_hit[2] = 1'b0;
        watch(2);
        q_hit[2] = 1'b1; watch(1); q_hit[2] = 1'b0;
        watch(25);
        chk(hi[2] == 10, "R4 edges during pulse ignored", hi[2], 10);
        clr();
        q_hit[2] = 1'b1; watch(1); q_hit[2] = 1'b0;
        watch(20);
        chk(hi[2] == 10, "R4 retrigger after end", hi[2], 10);
    endtask

    task automatic t_zero();
        plen = 6'd0;
        clr();
        q_hit[0] = 1'b1; watch(1); q_hit[0] = 1'b0;
        watch(10);
        chk(hi[0] == 0, "R5 zero length no pulse", hi[0], 0);
        plen = 6'd5;
    endtask

    task automatic t_tot();
        mode[3] = 1'b1;
        @(negedge clk); clr();
        q_hit[3] = 1'b1; watch(7); q_hit[3] = 1'b0; watch(10);
        chk(hi[3] == 7, "R6 tot follows level", hi[3], 7);
        chk(vc[3] == 1, "R7 one duration strobe", vc[3], 1);
        chk(ln[3] == 7, "R7 duration value", ln[3], 7);
        clr();
        c_hit[3] = 1'b1; watch(1); c_hit[3] = 1'b0; watch(10);
        chk(hi[3] == 0 && vc[3] == 0, "R6 current hit ignored in tot", hi[3], 0);
        clr();
        q_hit[3] = 1'b1; watch(40); q_hit[3] = 1'b0; watch(10);
        chk(hi[3] == 40, "R8 long tot width", hi[3], 40);
        chk(ln[3] == 31, "R8 duration saturates", ln[3], 31);
    endtask

    task automatic t_disable();
        en[0] = 1'b0; en[3] = 1'b0;
        watch(2); clr();
        q_hit[0] = 1'b1; q_hit[3] = 1'b1; watch(6);
        q_hit[0] = 1'b0; q_hit[3] = 1'b0; watch(10);
        chk(hi[0] == 0 && orc == 0, "R9 disabled one-shot lane", hi[0] + orc, 0);
        chk(hi[3] == 0 && vc[3] == 0, "R9 disabled tot lane", hi[3] + vc[3], 0);
        en[0] = 1'b1; en[3] = 1'b1;
        watch(2);
    endtask

    task automatic t_sum();
        plen = 6'd6;
        clr();
        q_hit[NCH] = 1'b1; watch(1); q_hit[NCH] = 1'b0; watch(15);
        chk(hi[NCH] == 6, "R10 sum lane pulse", hi[NCH], 6);
        chk(orc == 0, "R10 sum lane not in or", orc, 0);
        chk(rdc == 6, "R10 readout start from sum", rdc, 6);
    endtask

    task automatic t_indep();
        plen = 6'd4;
        clr();
        q_hit[0] = 1'b1; q_hit[3] = 1'b1; watch(9);
        q_hit[0] = 1'b0; q_hit[3] = 1'b0; watch(10);
        chk(hi[0] == 4, "R11 one-shot lane", hi[0], 4);
        chk(hi[3] == 9 && ln[3] == 9, "R11 tot lane", hi[3], 9);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_current();
        t_retrig();
        t_zero();
        t_tot();
        t_disable();
        t_sum();
        t_indep();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule